// File: doc/BRIEF.md
# Loadable Synchronous Up-Counter with Paired Enables

This block is a small binary up-counter, four bits wide by default, for use as a divider stage, a sequencer or a slice of a wider count chain. Every change of the count happens on the rising clock edge. On each edge the counter does exactly one of four things. In falling order of precedence, it can clear to zero, take a parallel value, step up by one, or keep its value.

Stepping needs two enables at once. One enable is active-high and the other is active-low, so either one can stall the count on its own. A terminal-count flag goes high when the count is all ones and the active-high enable is asserted. The flag does not depend on the active-low enable. It is formed combinationally from the count and that one enable, so it can drive the active-high enable of a following stage.

Top module: `lc_counter`

## Requirements
- R1: When `clr_n` is 0 at a rising edge, the count becomes 0 on that edge, whatever `load_n`, `load_val`, `run_hi` and `run_lo_n` are.
- R2: When `clr_n` is 1 and `load_n` is 0 at a rising edge, the count takes `load_val` on that edge, whatever the two enables are.
- R3: When `clr_n` and `load_n` are both 1, the count goes up by one on the edge only if `run_hi` is 1 and `run_lo_n` is 0.
- R4: When `clr_n` and `load_n` are both 1, the count keeps its value in the three other enable combinations: (`run_hi`,`run_lo_n`) = (0,0), (0,1) and (1,1).
- R5: Stepping up from the all-ones value (1111 at default width) gives 0000.
- R6: `carry_o` is 1 exactly when the count is all ones and `run_hi` is 1, whatever `run_lo_n` is.
- R7: `carry_o` is not registered. When `run_hi` changes between clock edges, `carry_o` follows it in the same cycle, with no clock edge needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| clr_n | input | 1 | Synchronous clear, active low, highest precedence |
| load_n | input | 1 | Synchronous parallel load, active low |
| load_val | input | W (4) | Value taken on a load |
| run_hi | input | 1 | Count enable, active high; also gates `carry_o` |
| run_lo_n | input | 1 | Count enable, active low |
| count_q | output | W (4) | Current count |
| carry_o | output | 1 | Terminal-count flag for cascading |

## Verification
Several controls can be active on the same edge: clear with load, load with both enables active, and a step taken from all ones while the carry flag is high. The bench drives each of these collisions on purpose and also mixes them at random. A behavioural model decides which control takes effect on each edge, and the count is compared with that model on every cycle. The carry flag is checked a short time after each input change, before the next edge. This includes the case where `run_hi` is toggled on an all-ones count while `run_lo_n` is held high, so that the counter holds and only the flag moves.

// File: rtl/lc_pkg.sv
// Package: shared types for the loadable counter.
// Assumes: one action is chosen per clock edge.
package lc_pkg;
    // Action taken by the counter on the coming rising edge
    typedef enum logic [1:0] {
        LC_HOLD  = 2'd0,
        LC_STEP  = 2'd1,
        LC_LOAD  = 2'd2,
        LC_CLEAR = 2'd3
    } lc_act_e;
endpackage

// File: rtl/lc_arbiter.sv
// Module: lc_arbiter
// Picks one action from the control inputs by fixed precedence:
// clear, then load, then step (both enables active), else hold.
// Assumes: all controls are synchronous to the counter clock.
module lc_arbiter
    import lc_pkg::*;
(
    input  logic    clr_n,
    input  logic    load_n,
    input  logic    run_hi,
    input  logic    run_lo_n,
    output lc_act_e act
);
    logic both_run;

    // Purpose: stepping needs both enables active at once
    always_comb begin
        both_run = run_hi & ~run_lo_n;
    end

    // Purpose: precedence chain that selects a single action
    always_comb begin
        if (!clr_n)        act = LC_CLEAR;
        else if (!load_n)  act = LC_LOAD;
        else if (both_run) act = LC_STEP;
        else               act = LC_HOLD;
    end
endmodule

// File: rtl/lc_next.sv
// Module: lc_next
// Forms the next count from the chosen action. The incrementer is a
// ripple of half adders, so all ones wraps to zero.
// Assumes: W >= 1.
module lc_next
    import lc_pkg::*;
#(
    parameter int W = 4
) (
    input  lc_act_e      act,
    input  logic [W-1:0] cur,
    input  logic [W-1:0] load_val,
    output logic [W-1:0] nxt
);
    logic [W:0]   rip;
    logic [W-1:0] inc;

    assign rip[0] = 1'b1;

    // Purpose: one half-adder stage per bit of the incrementer
    for (genvar i = 0; i < W; i++) begin : g_inc
        assign inc[i]   = cur[i] ^ rip[i];
        assign rip[i+1] = cur[i] & rip[i];
    end

    // Purpose: next-state mux driven by the arbiter's action
    always_comb begin
        unique case (act)
            LC_CLEAR: nxt = '0;
            LC_LOAD:  nxt = load_val;
            LC_STEP:  nxt = inc;
            default:  nxt = cur;
        endcase
    end
endmodule

// File: rtl/lc_carry.sv
// Module: lc_carry
// Raises the terminal-count flag when every bit of the count is one
// and the active-high enable is set. Purely combinational.
// Assumes: the active-low enable deliberately plays no part here.
module lc_carry #(
    parameter int W = 4
) (
    input  logic [W-1:0] cur,
    input  logic         run_hi,
    output logic         carry
);
    logic [W:0] ones;

    assign ones[0] = 1'b1;

    // Purpose: AND chain that detects the all-ones count
    for (genvar i = 0; i < W; i++) begin : g_ones
        assign ones[i+1] = ones[i] & cur[i];
    end

    // Purpose: gate the all-ones detect with the active-high enable
    always_comb begin
        carry = ones[W] & run_hi;
    end
endmodule

// File: rtl/lc_counter.sv
// Module: lc_counter (top)
// Synchronous up-counter with clear, parallel load, two count enables
// of opposite polarity and a combinational terminal-count flag.
// Assumes: clr_n serves as the synchronous active-low reset.
module lc_counter
    import lc_pkg::*;
#(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         clr_n,
    input  logic         load_n,
    input  logic [W-1:0] load_val,
    input  logic         run_hi,
    input  logic         run_lo_n,
    output logic [W-1:0] count_q,
    output logic         carry_o
);
    lc_act_e      act;
    logic [W-1:0] nxt;

    lc_arbiter u_arb (
        .clr_n    (clr_n),
        .load_n   (load_n),
        .run_hi   (run_hi),
        .run_lo_n (run_lo_n),
        .act      (act)
    );

    lc_next #(.W(W)) u_nxt (
        .act      (act),
        .cur      (count_q),
        .load_val (load_val),
        .nxt      (nxt)
    );

    lc_carry #(.W(W)) u_cry (
        .cur    (count_q),
        .run_hi (run_hi),
        .carry  (carry_o)
    );

    // Purpose: count register, updated on every rising edge
    always_ff @(posedge clk) begin
        count_q <= nxt;
    end
endmodule

// File: rtl/lc_counter_chk.sv
// Module: lc_counter_chk
// Checker bound to lc_counter. It is armed only after a clear has
// been seen, so an unknown power-up count never fires a check.
module lc_counter_chk #(
    parameter int W = 4
) (
    input logic         clk,
    input logic         clr_n,
    input logic         load_n,
    input logic [W-1:0] load_val,
    input logic         run_hi,
    input logic         run_lo_n,
    input logic [W-1:0] count_q,
    input logic         carry_o
);
    logic armed = 1'b0;

    // Purpose: arm the checks once the first clear has been taken
    always_ff @(posedge clk) begin
        if (!clr_n) armed <= 1'b1;
    end

    // R1
    clear_wins_chk: assert property (@(posedge clk) disable iff (!armed)
        !clr_n |=> count_q == '0);

    // R2
    load_takes_chk: assert property (@(posedge clk) disable iff (!armed)
        (clr_n && !load_n) |=> count_q == $past(load_val));

    // R3
    step_up_chk: assert property (@(posedge clk) disable iff (!armed)
        (clr_n && load_n && run_hi && !run_lo_n)
            |=> count_q == W'($past(count_q) + 1'b1));

    // R4
    hold_idle_chk: assert property (@(posedge clk) disable iff (!armed)
        (clr_n && load_n && !(run_hi && !run_lo_n)) |=> $stable(count_q));

    // R5
    wrap_zero_chk: assert property (@(posedge clk) disable iff (!armed)
        (clr_n && load_n && run_hi && !run_lo_n && count_q == '1)
            |=> count_q == '0);

    // R6
    carry_set_chk: assert property (@(posedge clk) disable iff (!armed)
        (count_q == '1 && run_hi) |-> carry_o);

    // R6
    carry_gate_chk: assert property (@(posedge clk) disable iff (!armed)
        carry_o |-> (run_hi && count_q == '1));
endmodule

bind lc_counter lc_counter_chk #(.W(W)) u_chk (
    .clk      (clk),
    .clr_n    (clr_n),
    .load_n   (load_n),
    .load_val (load_val),
    .run_hi   (run_hi),
    .run_lo_n (run_lo_n),
    .count_q  (count_q),
    .carry_o  (carry_o)
);

// File: tb/lc_counter_tb.sv
// Bench for lc_counter: a behavioural reference model is updated on
// every edge and compared with the outputs between edges.
module lc_counter_tb;
    localparam int W      = 4;
    localparam int PERIOD = 10;
    localparam int MAXV   = (1 << W) - 1;

    logic         clk = 1'b0;
    logic         clr_n = 1'b0;
    logic         load_n = 1'b1;
    logic [W-1:0] load_val = '0;
    logic         run_hi = 1'b0;
    logic         run_lo_n = 1'b1;
    logic [W-1:0] count_q;
    logic         carry_o;

    int n_cmp = 0;
    int n_bad = 0;
    int model = 0;
    string last_req = "R1";

    always #(PERIOD/2) clk = ~clk;

    lc_counter #(.W(W)) u_dut (
        .clk(clk), .clr_n(clr_n), .load_n(load_n), .load_val(load_val),
        .run_hi(run_hi), .run_lo_n(run_lo_n),
        .count_q(count_q), .carry_o(carry_o)
    );

    task automatic check_count();
        n_cmp++;
        if (int'(count_q) !== model) begin
            n_bad++;
            $display("FAIL %s count: actual %0d expected %0d", last_req, count_q, model);
        end
    endtask

    task automatic check_carry(string req);
        logic exp_c;
        exp_c = (model == MAXV) && run_hi;
        n_cmp++;
        if (carry_o !== exp_c) begin
            n_bad++;
            $display("FAIL %s carry: actual %b expected %b", req, carry_o, exp_c);
        end
    endtask

    // One cycle: compare count, apply inputs, check carry, advance model
    task automatic step(input logic c, input logic l, input int v,
                        input logic h, input logic lo);
        @(negedge clk);
        check_count();
        clr_n = c; load_n = l; load_val = W'(v); run_hi = h; run_lo_n = lo;
        #1;
        check_carry("R6");
        @(posedge clk);
        if (!c)                  begin model = 0;            last_req = "R1"; end
        else if (!l)             begin model = v & MAXV;     last_req = "R2"; end
        else if (h && !lo)       begin
            last_req = (model == MAXV) ? "R5" : "R3";
            model = (model + 1) & MAXV;
        end
        else                     last_req = "R4";
    endtask

    initial begin
        #(PERIOD * 100000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        // R1 reset state, and clear beats load plus active enables
        step(0, 0, 9, 1, 0);
        step(1, 0, 5, 0, 1);          // R2 load with enables idle
        step(1, 1, 0, 1, 0);          // R3 count
        step(1, 1, 0, 1, 0);
        step(1, 1, 0, 0, 0);          // R4 hold combos
        step(1, 1, 0, 0, 1);
        step(1, 1, 0, 1, 1);
        step(1, 0, 3, 1, 0);          // R2 load beats active enables
        step(1, 0, 14, 1, 0);
        step(1, 1, 0, 1, 0);          // to 15
        step(1, 1, 0, 1, 1);          // R6 hold at 15, carry high
        // R7 toggle run_hi on all-ones with run_lo_n deasserted
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            run_hi = k[0];
            #1;
            check_carry("R7");
            #1;
            run_hi = ~k[0];
            #1;
            check_carry("R7");
        end
        step(1, 1, 0, 0, 0);          // carry low with run_lo_n active
        step(1, 1, 0, 1, 0);          // R5 wrap
        step(1, 1, 0, 1, 0);
        step(0, 1, 0, 1, 0);          // R1 clear mid-count
        step(1, 0, 15, 0, 0);
        step(0, 0, 7, 1, 0);          // R1 clear with load
        for (int i = 0; i < 300; i++) begin
            step(($urandom % 12) != 0, ($urandom % 5) != 0, int'($urandom % 16),
                 ($urandom % 4) != 0, ($urandom % 4) == 0);
        end
        @(negedge clk);
        check_count();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule